// File: doc/BRIEF.md
# Dual-Channel Converter Serial Output Engine

This block is the output side of a two-channel sampling converter. A host pulls an active-low chip select low and toggles a serial clock. The block then sends two 12-bit conversion results back, one per serial data line. The analog front end and the converter itself lie outside the block. Their results arrive as two parallel words, which must be valid when chip select falls. The block captures both words at that moment.

After chip select falls, the block counts falling edges of the serial clock. The first 18 counted edges form a conversion window, and both lines stay released during it. Each data line has an enable output that an I/O pad turns into high impedance. On counted edge 19, both lines are enabled and begin shifting out their own channel's result, MSB first, one bit per falling edge. If the host keeps chip select low past the first result, each line then carries the other channel's result. After a short driven tail, the lines are released. Chip select rising releases both lines at any point in the frame.

Serial clock and chip select are asynchronous to the block clock. They are synchronised and edge-detected, and the outputs are registered. A serial-clock fall that arrives together with the chip-select fall is not counted.

Top module: `adc_dual_sdo`

## Requirements
- R1: After reset, and whenever chip select has been high for `SYNC+1` block clock cycles, both enables are 0 and both data outputs are 0. A data output is 0 whenever its enable is 0.
- R2: For counted falling edges 1 through 18 of a frame, both enables stay 0.
- R3: On counted edge 19, both enables become 1. Line A carries bit 11 of channel A's word and line B carries bit 11 of channel B's word.
- R4: On counted edge n, for n from 19 to 30, line A carries channel A bit 30−n and line B carries channel B bit 30−n. The LSB, bit 0, appears on edge 30.
- R5: On counted edge n, for n from 31 to 42, line A carries channel B bit 42−n and line B carries channel A bit 42−n.
- R6: On counted edges 43 and 44, both lines stay enabled and drive 0. From edge 45 onward, both enables are 0 until chip select rises.
- R7: A chip-select rise at any point in a frame sets both enables and both data outputs to 0 within `SYNC+2` block clock cycles.
- R8: A serial-clock fall that reaches the block in the same synchronised sample as the chip-select fall is not counted. The next fall is counted as edge 1.
- R9: Both result words are captured when chip select falls. Changes on the result inputs during a frame do not alter the bits sent in that frame.
- R10: Serial-clock falls while chip select is high are not counted, and every frame starts counting from edge 1.
- R11: Between counted edges, the data outputs and enables do not change while chip select stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; samples the serial inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host, idle high |
| res_a | input | 12 | Channel A conversion result |
| res_b | input | 12 | Channel B conversion result |
| dout_a | output | 1 | Serial data for line A |
| doe_a | output | 1 | Drive enable for line A; 0 means high impedance |
| dout_b | output | 1 | Serial data for line B |
| doe_b | output | 1 | Drive enable for line B; 0 means high impedance |

## Verification
A wrong edge count shows up at the ports within one serial-clock period. The enables rise on the wrong edge, or every later bit on both lines is shifted by one position. An error in the lane crossing is first visible on counted edge 31, where line A would repeat channel A's MSB instead of channel B's. If the word capture were not held, the first bit after an input change would differ from the captured word, within one edge. A stale release path would leave an enable high `SYNC+2` cycles after chip select rises, or after edge 45.

// File: rtl/adc_sdo_pkg.sv
package adc_sdo_pkg;

  typedef enum logic [2:0] {
    PH_QUIET,
    PH_OWN,
    PH_CROSS,
    PH_TAIL,
    PH_DONE
  } phase_e;

  // Frame phase that a given counted-edge number falls into.
  function automatic phase_e phase_of(input int unsigned c,
                                      input int unsigned conv,
                                      input int unsigned w,
                                      input int unsigned tail);
    if (c < conv)              return PH_QUIET;
    if (c < conv + w)          return PH_OWN;
    if (c < conv + 2 * w)      return PH_CROSS;
    if (c < conv + 2 * w + tail) return PH_TAIL;
    return PH_DONE;
  endfunction

  // Bit position within a word for edge c of a section starting at base.
  function automatic int unsigned bit_sel(input int unsigned c,
                                          input int unsigned base,
                                          input int unsigned w);
    return (w - 1) - (c - base);
  endfunction

endpackage

// File: rtl/adc_sdo_sync.sv
module adc_sdo_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] st;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= '1;
        else        st <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= '1;
        else        st <= {st[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = st[STAGES-1];

endmodule

// File: rtl/adc_sdo_edge.sv
module adc_sdo_edge #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_s,
  input  logic          sclk_s,
  output logic          frame_on,
  output logic          cs_fall,
  output logic          edge_stb,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nx
);

  logic cs_d;
  logic sclk_d;
  logic sclk_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b1;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign frame_on  = ~cs_s;
  assign cs_fall   = cs_d & ~cs_s;
  assign sclk_fall = sclk_d & ~sclk_s;
  // A fall seen in the same sample as the select fall is skipped.
  assign edge_stb  = sclk_fall & ~cs_s & ~cs_d;
  assign cnt_nx    = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!frame_on) cnt_q <= '0;
    else if (edge_stb)  cnt_q <= cnt_nx;
  end

endmodule

// File: rtl/adc_sdo_lane.sv
module adc_sdo_lane
  import adc_sdo_pkg::*;
#(
  parameter int W    = 12,
  parameter int CONV = 19,
  parameter int TAIL = 2,
  parameter int CW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_on,
  input  logic          edge_stb,
  input  logic [CW-1:0] cnt_nx,
  input  logic [W-1:0]  own,
  input  logic [W-1:0]  other,
  output logic          dout,
  output logic          doe
);

  localparam int IW = (W > 1) ? $clog2(W) : 1;

  phase_e        ph;
  logic [IW-1:0] idx_own;
  logic [IW-1:0] idx_oth;
  logic          nb;

  always_comb begin
    ph      = phase_of(32'(cnt_nx), CONV, W, TAIL);
    idx_own = IW'(bit_sel(32'(cnt_nx), CONV, W));
    idx_oth = IW'(bit_sel(32'(cnt_nx), CONV + W, W));
    unique case (ph)
      PH_OWN:   nb = own[idx_own];
      PH_CROSS: nb = other[idx_oth];
      default:  nb = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= 1'b0;
      doe  <= 1'b0;
    end else if (!frame_on) begin
      dout <= 1'b0;
      doe  <= 1'b0;
    end else if (edge_stb) begin
      dout <= nb;
      doe  <= (ph == PH_OWN) || (ph == PH_CROSS) || (ph == PH_TAIL);
    end
  end

endmodule

// File: rtl/adc_dual_sdo.sv
module adc_dual_sdo #(
  parameter int W    = 12,
  parameter int CONV = 19,
  parameter int TAIL = 2,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic [W-1:0] res_a,
  input  logic [W-1:0] res_b,
  output logic         dout_a,
  output logic         doe_a,
  output logic         dout_b,
  output logic         doe_b
);

  localparam int FRAME_END = CONV + 2 * W + TAIL;
  localparam int CW        = $clog2(FRAME_END + 1) + 1;

  logic [1:0]        sync_q;
  logic              cs_s;
  logic              sclk_s;
  logic              frame_on;
  logic              cs_fall;
  logic              edge_stb;
  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     cnt_nx;
  logic [1:0][W-1:0] word;
  logic [1:0]        dout_v;
  logic [1:0]        doe_v;

  adc_sdo_sync #(.STAGES(SYNC), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, sclk}),
    .q     (sync_q)
  );

  assign cs_s   = sync_q[1];
  assign sclk_s = sync_q[0];

  adc_sdo_edge #(.CW(CW)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .sclk_s   (sclk_s),
    .frame_on (frame_on),
    .cs_fall  (cs_fall),
    .edge_stb (edge_stb),
    .cnt_q    (cnt_q),
    .cnt_nx   (cnt_nx)
  );

  // Capture both results at the sample point.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word <= '0;
    else if (cs_fall) word <= {res_b, res_a};
  end

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      adc_sdo_lane #(.W(W), .CONV(CONV), .TAIL(TAIL), .CW(CW)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_on (frame_on),
        .edge_stb (edge_stb),
        .cnt_nx   (cnt_nx),
        .own      (word[g]),
        .other    (word[1-g]),
        .dout     (dout_v[g]),
        .doe      (doe_v[g])
      );
    end
  endgenerate

  assign dout_a = dout_v[0];
  assign doe_a  = doe_v[0];
  assign dout_b = dout_v[1];
  assign doe_b  = doe_v[1];

endmodule

// File: rtl/adc_dual_sdo_chk.sv
module adc_dual_sdo_chk #(
  parameter int W    = 12,
  parameter int CONV = 19,
  parameter int TAIL = 2,
  parameter int CW   = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_on,
  input logic          cs_fall,
  input logic          edge_stb,
  input logic [CW-1:0] cnt_q,
  input logic          dout_a,
  input logic          doe_a,
  input logic          dout_b,
  input logic          doe_b
);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_on |=> (!doe_a && !doe_b && !dout_a && !dout_b));

  // R2
  window_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doe_a |-> (cnt_q >= CW'(CONV) && cnt_q < CW'(CONV + 2 * W + TAIL)));

  // R3
  lane_enable_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doe_a == doe_b);

  // R8
  coincident_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |-> !edge_stb);

  // R10
  idle_count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_on |=> (cnt_q == '0));

  // R11
  hold_between_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frame_on) && !$past(edge_stb)) |->
      ($stable(dout_a) && $stable(doe_a) && $stable(dout_b) && $stable(doe_b)));

endmodule

bind adc_dual_sdo adc_dual_sdo_chk #(
  .W(W), .CONV(CONV), .TAIL(TAIL), .CW(CW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .frame_on (frame_on),
  .cs_fall  (cs_fall),
  .edge_stb (edge_stb),
  .cnt_q    (cnt_q),
  .dout_a   (dout_a),
  .doe_a    (doe_a),
  .dout_b   (dout_b),
  .doe_b    (doe_b)
);

// File: tb/sim_adc_dual_sdo.sv
module sim_adc_dual_sdo;

  localparam int HP = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] ra = '0;
  logic [11:0] rb = '0;
  logic        dout_a, doe_a, dout_b, doe_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  adc_dual_sdo u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .res_a(ra), .res_b(rb),
    .dout_a(dout_a), .doe_a(doe_a), .dout_b(dout_b), .doe_b(doe_b)
  );

  // {res_a, res_b, edges before chip select rises}
  localparam logic [31:0] VEC [6] = '{
    {12'hA5A, 12'h3C3, 8'd46},
    {12'hFFF, 12'h000, 8'd46},
    {12'h800, 12'h001, 8'd31},
    {12'h123, 12'hFED, 8'd46},
    {12'h000, 12'hFFF, 8'd40},
    {12'h7FE, 12'h801, 8'd47}
  };

  // Expected {enable, data} for one line on counted edge c.
  function automatic logic [1:0] expect_line(int c, logic [11:0] mine, logic [11:0] theirs);
    if (c <= 18) return 2'b00;
    if (c <= 30) return {1'b1, mine[30 - c]};
    if (c <= 42) return {1'b1, theirs[42 - c]};
    if (c <= 44) return 2'b10;
    return 2'b00;
  endfunction

  function automatic string tag_of(int c);
    if (c <= 18) return "R2";
    if (c == 19) return "R3";
    if (c <= 30) return "R4";
    if (c <= 42) return "R5";
    return "R6";
  endfunction

  task automatic check_lines(string tag, int c, logic [11:0] ma, logic [11:0] mb);
    logic [1:0] ea, eb;
    ea = expect_line(c, ma, mb);
    eb = expect_line(c, mb, ma);
    checks++;
    if ({doe_a, dout_a} !== ea || {doe_b, dout_b} !== eb) begin
      fails++;
      $display("FAIL %s edge %0d: got a=%b%b b=%b%b expected a=%b b=%b",
               tag, c, doe_a, dout_a, doe_b, dout_b, ea, eb);
    end
  endtask

  task automatic check_off(string tag);
    checks++;
    if ({doe_a, dout_a, doe_b, dout_b} !== 4'b0000) begin
      fails++;
      $display("FAIL %s released: got %b%b%b%b expected 0000",
               tag, doe_a, dout_a, doe_b, dout_b);
    end
  endtask

  task automatic sclk_fall();
    @(negedge clk) sclk = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic sclk_rise();
    sclk = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic frame_open();
    @(negedge clk) cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic frame_close();
    cs_n = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [11:0] ca, cb;
    repeat (3) @(negedge clk);
    check_off("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_off("R1");

    // Table-driven frames
    for (int v = 0; v < 6; v++) begin
      ra = VEC[v][31:20];
      rb = VEC[v][19:8];
      frame_open();
      for (int c = 1; c <= int'(VEC[v][7:0]); c++) begin
        sclk_fall();
        check_lines(tag_of(c), c, VEC[v][31:20], VEC[v][19:8]);
        sclk_rise();
        check_lines("R11", c, VEC[v][31:20], VEC[v][19:8]);
      end
      frame_close();
      check_off("R7");
    end

    // R10: falls with chip select high are not counted
    ra = 12'h9C6; rb = 12'h63A;
    for (int k = 0; k < 25; k++) begin
      sclk_fall();
      if (k == 24) check_off("R10");
      sclk_rise();
    end
    frame_open();
    for (int c = 1; c <= 20; c++) begin
      sclk_fall();
      if (c >= 18) check_lines("R10", c, 12'h9C6, 12'h63A);
      sclk_rise();
    end
    frame_close();

    // R8: serial clock falls together with chip select
    ra = 12'h5A3; rb = 12'hC0F;
    @(negedge clk) begin cs_n = 1'b0; sclk = 1'b0; end
    repeat (HP) @(negedge clk);
    sclk_rise();
    for (int c = 1; c <= 20; c++) begin
      sclk_fall();
      if (c >= 18) check_lines("R8", c, 12'h5A3, 12'hC0F);
      sclk_rise();
    end
    frame_close();

    // R9: inputs change mid-frame
    ca = 12'hABC; cb = 12'h135;
    ra = ca; rb = cb;
    frame_open();
    for (int c = 1; c <= 42; c++) begin
      sclk_fall();
      if (c == 5) begin ra = ~ca; rb = ~cb; end
      if (c >= 19) check_lines("R9", c, ca, cb);
      sclk_rise();
    end
    frame_close();

    // R7: early release inside the first result, then idle falls
    ra = 12'hF0F; rb = 12'h0F0;
    frame_open();
    for (int c = 1; c <= 25; c++) begin
      sclk_fall();
      if (c == 25) check_lines("R4", c, 12'hF0F, 12'h0F0);
      sclk_rise();
    end
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check_off("R7");
    for (int k = 0; k < 3; k++) begin
      sclk_fall();
      check_off("R10");
      sclk_rise();
    end

    finish_run();
  end

endmodule